// File: doc/BRIEF.md
# Inter-Packet Gap Deferral Timer

This block decides when a half-duplex 10 Mb/s Ethernet transmitter may begin sending a frame. It watches a carrier-sense input. After carrier falls it times the inter-packet gap in bit-time ticks, which it derives from the system clock. Once the gap has run out, it issues a one-clock start grant, but only if a frame is waiting and no backoff is in progress. While it waits for carrier to end, or while it times the gap, it raises a deferring status.

A mode input picks one of two deferral rules:

- **Two-part (mode low):** carrier seen during the early portion of the gap sends the timer back to wait for carrier to clear. Carrier seen in the late portion is ignored, and the gap still expires on time.
- **Simple (mode high):** any carrier seen during the gap restarts it.

After a grant, the block stays quiet until the transmitter reports end of frame. It then waits for carrier to be low and times a fresh gap. Out of reset the medium counts as having been idle for a full gap, so a frame that is already pending is granted at once.

Top module: `tx_defer_timer`

## Requirements
- R1: After reset, deferring_o is 0. A pending frame (tx_pending_i=1, backoff_i=0, carrier_i=0) is granted in the first cycle after reset is released.
- R2: While the gap has expired, carrier_i=1 blocks any grant in that cycle. From the next cycle, deferring_o is 1 until the gap expires again.
- R3: The gap lasts exactly GAP_BITS*CLKS_PER_BIT clocks. Counting starts from the first clock edge that samples carrier_i=0 while deferring. deferring_o stays 1 for those clocks, plus the one clock in which carrier was seen low.
- R4: In two-part mode (simple_mode_i=0), carrier_i=1 during the first WINDOW_BITS*CLKS_PER_BIT clocks of the gap restarts deferral. A full gap is then timed after carrier falls again.
- R5: In two-part mode, carrier_i=1 after the first WINDOW_BITS*CLKS_PER_BIT clocks of the gap is ignored. The gap expires at the same clock it would have expired without that carrier.
- R6: In simple mode (simple_mode_i=1), carrier_i=1 at any clock of the gap restarts deferral.
- R7: A grant is given only when tx_pending_i=1 and backoff_i=0. If either condition fails after the gap has expired, no grant is issued and deferring_o stays 0. A grant follows in the first cycle in which both conditions hold and carrier_i=0.
- R8: tx_start_o is a one-clock pulse. After it, there is no grant and deferring_o stays 0 until tx_done_i=1 is sampled. After that, the block defers, waits for carrier_i=0, and times a full gap.
- R9: deferring_o is 1 exactly while the block is waiting for carrier to clear or is timing the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_i | input | 1 | Carrier sense from the line |
| simple_mode_i | input | 1 | 0 selects two-part deferral, 1 selects simple deferral |
| tx_pending_i | input | 1 | A frame is ready to send |
| backoff_i | input | 1 | The transmitter is in backoff |
| tx_done_i | input | 1 | The transmitter has finished the granted frame |
| tx_start_o | output | 1 | One-clock grant to start transmission |
| deferring_o | output | 1 | The block is waiting for carrier to clear or is timing the gap |

## Verification
The bound checker watches every cycle for four properties:

- the exact gap length, measured from gap start to expiry;
- that restarts happen only inside the early window in two-part mode, and always in simple mode;
- that the grant is a single pulse;
- that a grant never coincides with carrier, backoff or an empty queue.

Other behaviour can only be shown by the bench's scenarios. These are the end-to-end latency from end of frame to the next grant, the holding of a pending frame across backoff, and the grant straight out of reset. The bench drives directed carrier bursts on both sides of the window edge and long random traffic, and compares both outputs against its own timeline model.

// File: rtl/defer_pkg.sv
package defer_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BUSY  = 2'd1,
    ST_GAP   = 2'd2,
    ST_SEND  = 2'd3
  } defer_state_t;

  // Number of system clocks covered by a span of bit times.
  function automatic int span_clocks(int clks_per_bit, int bits);
    return clks_per_bit * bits;
  endfunction

endpackage

// File: rtl/bit_tick_gen.sv
module bit_tick_gen #(
  parameter int CLKS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [W-1:0] pre_q;

  assign tick = run && (pre_q == W'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int GAP_BITS    = 96,
  parameter int WINDOW_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic in_window,
  output logic expire_now
);
  localparam int BW = $clog2(GAP_BITS + 1);

  logic [BW-1:0] bits_q;

  assign in_window  = bits_q < BW'(WINDOW_BITS);
  assign expire_now = tick && (bits_q == BW'(GAP_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) bits_q <= '0;
    else if (tick)      bits_q <= bits_q + 1'b1;
  end
endmodule

// File: rtl/defer_fsm.sv
module defer_fsm
  import defer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic carrier,
  input  logic simple_mode,
  input  logic pending,
  input  logic backoff,
  input  logic tx_done,
  input  logic in_window,
  input  logic expire_now,
  output logic tx_start,
  output logic deferring,
  output logic in_gap,
  output logic gap_start,
  output logic gap_restart,
  output logic gap_expire
);
  defer_state_t st_q, st_d;

  assign in_gap      = (st_q == ST_GAP);
  assign gap_start   = (st_q == ST_BUSY) && !carrier;
  assign gap_restart = in_gap && carrier && (simple_mode || in_window);
  assign gap_expire  = in_gap && !gap_restart && expire_now;
  assign tx_start    = (st_q == ST_READY) && !carrier && pending && !backoff;
  assign deferring   = (st_q == ST_BUSY) || (st_q == ST_GAP);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READY: if (carrier) st_d = ST_BUSY;
                else if (tx_start) st_d = ST_SEND;
      ST_BUSY:  if (gap_start) st_d = ST_GAP;
      ST_GAP:   if (gap_restart) st_d = ST_BUSY;
                else if (gap_expire) st_d = ST_READY;
      ST_SEND:  if (tx_done) st_d = ST_BUSY;
      default:  st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_READY;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int CLKS_PER_BIT = 10,
  parameter int GAP_BITS     = 96,
  parameter int WINDOW_BITS  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  input  logic simple_mode_i,
  input  logic tx_pending_i,
  input  logic backoff_i,
  input  logic tx_done_i,
  output logic tx_start_o,
  output logic deferring_o
);
  logic tick, in_window, expire_now;
  logic in_gap, gap_start, gap_restart, gap_expire;

  bit_tick_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(in_gap), .tick(tick)
  );

  gap_counter #(.GAP_BITS(GAP_BITS), .WINDOW_BITS(WINDOW_BITS)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(in_gap), .tick(tick),
    .in_window(in_window), .expire_now(expire_now)
  );

  defer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .carrier(carrier_i), .simple_mode(simple_mode_i),
    .pending(tx_pending_i), .backoff(backoff_i), .tx_done(tx_done_i),
    .in_window(in_window), .expire_now(expire_now),
    .tx_start(tx_start_o), .deferring(deferring_o), .in_gap(in_gap),
    .gap_start(gap_start), .gap_restart(gap_restart), .gap_expire(gap_expire)
  );
endmodule

// File: rtl/tx_defer_checker.sv
module tx_defer_checker #(
  parameter int CLKS_PER_BIT = 10,
  parameter int GAP_BITS     = 96,
  parameter int WINDOW_BITS  = 64
) (
  input logic clk,
  input logic rst_n,
  input logic carrier_i,
  input logic simple_mode_i,
  input logic tx_pending_i,
  input logic backoff_i,
  input logic tx_start_o,
  input logic in_gap,
  input logic gap_start,
  input logic gap_restart,
  input logic gap_expire
);
  localparam int GAP_CLKS = defer_pkg::span_clocks(CLKS_PER_BIT, GAP_BITS);
  localparam int WIN_CLKS = defer_pkg::span_clocks(CLKS_PER_BIT, WINDOW_BITS);

  int unsigned gap_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap_age <= 0;
    else if (gap_start)           gap_age <= 0;
    else if (gap_age < 32'hFFFF_FFFF) gap_age <= gap_age + 1;
  end

  a_r3_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expire |-> gap_age == GAP_CLKS - 1);

  a_r4_restart_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    gap_restart |-> (simple_mode_i || gap_age < WIN_CLKS));

  a_r5_late_carrier_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!simple_mode_i && in_gap && carrier_i && gap_age >= WIN_CLKS) |-> !gap_restart);

  a_r6_simple_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (simple_mode_i && in_gap && carrier_i) |-> gap_restart);

  a_r7_grant_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> (tx_pending_i && !backoff_i && !carrier_i));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |=> !tx_start_o);
endmodule

bind tx_defer_timer tx_defer_checker #(
  .CLKS_PER_BIT(CLKS_PER_BIT), .GAP_BITS(GAP_BITS), .WINDOW_BITS(WINDOW_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .carrier_i(carrier_i), .simple_mode_i(simple_mode_i),
  .tx_pending_i(tx_pending_i), .backoff_i(backoff_i), .tx_start_o(tx_start_o),
  .in_gap(in_gap), .gap_start(gap_start), .gap_restart(gap_restart),
  .gap_expire(gap_expire)
);

// File: tb/test_tx_defer_timer.sv
module test_tx_defer_timer;
  localparam int CPB = 10;
  localparam int GB  = 96;
  localparam int WB  = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic carrier = 0, simple = 0, pending = 0, backoff = 0, done = 0;
  logic tx_start, deferring;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench timeline model: 0 idle-expired, 1 waiting carrier low, 2 timing, 3 sending
  int m_ph = 0;
  int m_elapsed = 0;

  always #5 clk = ~clk;

  tx_defer_timer #(.CLKS_PER_BIT(CPB), .GAP_BITS(GB), .WINDOW_BITS(WB)) i_tx_defer_timer (
    .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .simple_mode_i(simple),
    .tx_pending_i(pending), .backoff_i(backoff), .tx_done_i(done),
    .tx_start_o(tx_start), .deferring_o(deferring)
  );

  function automatic int gap_len();
    return GB * CPB;
  endfunction

  function automatic int window_len();
    return WB * CPB;
  endfunction

  function automatic logic exp_start();
    return (m_ph == 0) && !carrier && pending && !backoff;
  endfunction

  function automatic logic exp_defer();
    return (m_ph == 1) || (m_ph == 2);
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic model_update();
    case (m_ph)
      0: if (carrier) m_ph = 1;
         else if (pending && !backoff) m_ph = 3;
      1: if (!carrier) begin m_ph = 2; m_elapsed = 0; end
      2: begin
           m_elapsed++;
           if (carrier && (simple || (m_elapsed - 1) < window_len())) m_ph = 1;
           else if (m_elapsed == gap_len()) m_ph = 0;
         end
      default: if (done) m_ph = 1;
    endcase
  endtask

  task automatic step(string tag);
    @(negedge clk);
    check(tag, tx_start, exp_start(), "tx_start_o");
    check(tag, deferring, exp_defer(), "deferring_o");
    @(posedge clk);
    model_update();
    #1;
  endtask

  // run until the model is timing with 'c' gap clocks already elapsed
  task automatic run_to_gap(int c, string tag);
    while (!(m_ph == 2 && m_elapsed == c)) step(tag);
  endtask

  task automatic finish_tx(string tag);
    done = 1; step(tag); done = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int defer_cnt;
    int grant_seen;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 pending = 1;
    rst_n = 1;
    m_ph = 0;

    // R1: reset state and immediate grant
    @(negedge clk);
    check("R1", deferring, 1'b0, "deferring_o after reset");
    check("R1", tx_start, 1'b1, "tx_start_o after reset");
    @(posedge clk); model_update(); #1;

    // R8: no further grant while sending
    repeat (20) step("R8");
    check("R8", tx_start, 1'b0, "tx_start_o while sending");

    // R3: full gap after end of frame, measure deferring span
    finish_tx("R8");
    defer_cnt = 0; grant_seen = 0;
    while (!grant_seen) begin
      @(negedge clk);
      if (deferring) defer_cnt++;
      grant_seen = tx_start;
      check("R3", tx_start, exp_start(), "tx_start_o");
      check("R3", deferring, exp_defer(), "deferring_o");
      @(posedge clk); model_update(); #1;
    end
    checks++;
    if (defer_cnt != gap_len() + 1) begin
      errors++;
      $display("FAIL R3 deferring span actual=%0d expected=%0d", defer_cnt, gap_len() + 1);
    end

    // R4: two-part, carrier inside early window restarts
    simple = 0;
    finish_tx("R4");
    run_to_gap(window_len() - 1, "R4");
    carrier = 1; step("R4"); carrier = 0;
    @(negedge clk);
    check("R4", deferring, 1'b1, "deferring_o after early carrier");
    @(posedge clk); model_update(); #1;
    while (m_ph != 3) step("R4");

    // R5: two-part, carrier after window ignored
    finish_tx("R5");
    run_to_gap(window_len(), "R5");
    carrier = 1; repeat (5) step("R5"); carrier = 0;
    while (m_ph != 3) step("R5");

    // R6: simple mode, late carrier restarts
    simple = 1;
    finish_tx("R6");
    run_to_gap(gap_len() - 2, "R6");
    carrier = 1; step("R6"); carrier = 0;
    repeat (3) step("R6");
    check("R6", deferring, 1'b1, "deferring_o after late carrier");
    while (m_ph != 3) step("R6");
    simple = 0;

    // R7: backoff and no pending hold off the grant
    backoff = 1;
    finish_tx("R7");
    while (m_ph != 0) step("R7");
    repeat (30) step("R7");
    backoff = 0; pending = 0;
    repeat (30) step("R7");
    pending = 1;
    step("R7");

    // R2: carrier while expired blocks grant
    finish_tx("R2");
    pending = 0;
    while (m_ph != 0) step("R2");
    carrier = 1; pending = 1;
    step("R2");
    repeat (10) step("R2");
    carrier = 0;
    while (m_ph != 3) step("R2");

    // R9: random traffic against the timeline model
    for (int i = 0; i < 60000; i++) begin
      if ($urandom_range(0, 399) == 0) carrier = ~carrier;
      if ($urandom_range(0, 99) == 0)  pending = ~pending;
      if ($urandom_range(0, 199) == 0) backoff = ~backoff;
      if ($urandom_range(0, 4999) == 0) simple = ~simple;
      done = ($urandom_range(0, 59) == 0);
      step("R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule